// File: doc/BRIEF.md
# Byte-Lane Synchronous Port Data Path

This block is the data path of one port of a synchronous word memory. The word is 36 bits wide and is split into four 9-bit byte lanes. On each rising clock edge the block samples two chip selects of opposite polarity, four active-low lane enables, a read/write select, an address and write data. From these it writes the chosen lanes into an internal array or reads them back. Each lane that carries read data raises its own drive-enable output, which stands in for a tri-state pad. A lane that is not driven shows zero on the read bus.

Read latency depends on a mode input. In flow-through mode the data follows the sampling edge within the same cycle. In pipelined mode it comes one edge later, with the lane enables registered together with the data. An output-disable input acts without the clock and silences every lane at once. Every sampling edge is classified into one of four access states, held in the control register: `ACC_DESEL` (a chip select is inactive), `ACC_IDLE` (selected, but no lane enabled), `ACC_WRITE` and `ACC_READ`. Any state can move to any other on the next edge, according to the decode of that edge: deselect, idle, write or read. The output stage keeps a second, pipelined copy of the read lanes.

Top module: `psd_port`

## Requirements
- R1: Lane n of the word occupies bits 9n+8 down to 9n (lane 0 = bits 0..8, lane 3 = bits 27..35). A lane enable `be_n[n]` controls only those bits, for both writes and reads.
- R2: When `ce0_n` is 1 or `ce1` is 0 at an edge, nothing is written, and no lane drives in the following cycle.
- R3: When the port is selected and `be_n` is 4'b1111, nothing is written and no lane drives in the following cycle.
- R4: A selected edge with `rw` = 0 writes `wdata` into every lane whose `be_n` bit is 0, at `addr`. The other lanes at that address keep their contents.
- R5: In flow-through mode (`pipe_mode` = 0), after a selected edge with `rw` = 1, `lane_drv` equals `~be_n` and those lanes of `rdata` carry the stored word. Undriven lanes read as zero. This holds from just after that edge until the next edge.
- R6: In pipelined mode (`pipe_mode` = 1), the lanes and data of a read appear one edge later than in R5 and hold until the edge after that.
- R7: While `oe_n` is 1, `lane_drv` and `rdata` are zero with no clock edge needed. When `oe_n` returns to 0, the pending read lanes reappear.
- R8: In the cycle after an edge that performs a write, no lane drives, in either mode, even with `oe_n` at 0.
- R9: Any pattern of the four lane enables is accepted in one access.
- R10: During reset, `lane_drv` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control and output registers |
| ce0_n | input | 1 | Chip select, active low |
| ce1 | input | 1 | Chip select, active high |
| be_n | input | 4 | Lane enables, active low, bit n = lane n |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Word address |
| wdata | input | 36 | Write data |
| oe_n | input | 1 | Asynchronous output disable, active high |
| pipe_mode | input | 1 | 0 = flow-through, 1 = pipelined read |
| rdata | output | 36 | Read data, zero on undriven lanes |
| lane_drv | output | 4 | Per-lane drive enable |

## Verification
A wrong access state shows at the ports in the cycle right after the faulty edge. `lane_drv` then either rises after a write or deselect, or fails to follow `~be_n` after a read. A lane enable routed to the wrong bits, or a write that disturbs a masked lane, first shows on a later read of that address. A mistake in the pipeline register appears one edge after a pipelined read, as a misplaced or missing lane pattern.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
    typedef enum logic [1:0] {
        ACC_DESEL = 2'd0,
        ACC_IDLE  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_READ  = 2'd3
    } acc_e;
endpackage

// File: rtl/psd_ctrl.sv
`timescale 1ns/1ps
module psd_ctrl
    import psd_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic [LANES-1:0]  be_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    output logic [LANES-1:0]  wr_lanes,
    output acc_e              st_q,
    output logic [LANES-1:0]  mask_q,
    output logic [ADDR_W-1:0] addr_q
);
    localparam logic [LANES-1:0] NONE = '1;

    acc_e             st_d;
    logic [LANES-1:0] mask_d;
    logic             sel;

    assign sel = !ce0_n && ce1;

    // decode of the sampled controls into the next access state
    always_comb begin
        st_d = ACC_DESEL;
        if (sel) begin
            if (be_n == NONE)
                st_d = ACC_IDLE;
            else if (rw)
                st_d = ACC_READ;
            else
                st_d = ACC_WRITE;
        end
    end

    // outputs per state: lane write strobes and read lane mask
    always_comb begin
        wr_lanes = '0;
        mask_d   = '0;
        unique case (st_d)
            ACC_DESEL: ;
            ACC_IDLE:  ;
            ACC_WRITE: wr_lanes = ~be_n;
            ACC_READ:  mask_d   = ~be_n;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ACC_DESEL;
            mask_q <= '0;
            addr_q <= '0;
        end else begin
            st_q   <= st_d;
            mask_q <= mask_d;
            addr_q <= addr;
        end
    end

    // R2: an inactive chip select leads to the deselected state
    p_desel_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce0_n || !ce1) |=> (st_q == ACC_DESEL && mask_q == '0));

    // R3: selected with no lane enabled gives the idle state
    p_no_lane_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce0_n && ce1 && be_n == NONE) |=> (st_q == ACC_IDLE && mask_q == '0));
endmodule

// File: rtl/psd_lanes.sv
`timescale 1ns/1ps
module psd_lanes #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lanes[g])
                store[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_word[g*LANE_W +: LANE_W] = store[rd_addr];
    end
endmodule

// File: rtl/psd_outstage.sv
`timescale 1ns/1ps
module psd_outstage
    import psd_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pipe_mode,
    input  logic                    oe_n,
    input  acc_e                    st_q,
    input  logic [LANES-1:0]        mask_q,
    input  logic [LANES*LANE_W-1:0] word,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        lane_drv
);
    localparam int WORD_W = LANES * LANE_W;

    logic [LANES-1:0]  ft_mask;
    logic [LANES-1:0]  pp_mask;
    logic [WORD_W-1:0] pp_data;
    logic [LANES-1:0]  src_mask;
    logic [WORD_W-1:0] src_data;
    logic              quiet;

    always_comb begin
        ft_mask = '0;
        unique case (st_q)
            ACC_DESEL: ;
            ACC_IDLE:  ;
            ACC_WRITE: ;
            ACC_READ:  ft_mask = mask_q;
        endcase
    end

    // second stage: lane mask kept in step with the data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp_mask <= '0;
            pp_data <= '0;
        end else begin
            pp_mask <= ft_mask;
            pp_data <= word;
        end
    end

    assign src_mask = pipe_mode ? pp_mask : ft_mask;
    assign src_data = pipe_mode ? pp_data : word;
    assign quiet    = oe_n || (st_q == ACC_WRITE);
    assign lane_drv = quiet ? '0 : src_mask;

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign rdata[g*LANE_W +: LANE_W] =
            lane_drv[g] ? src_data[g*LANE_W +: LANE_W] : '0;
    end

    // R6: pipelined lanes are the flow-through lanes of one edge earlier
    p_pipe_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !oe_n && st_q != ACC_WRITE) |-> (lane_drv == $past(ft_mask)));
endmodule

// File: rtl/psd_port.sv
`timescale 1ns/1ps
module psd_port
    import psd_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce0_n,
    input  logic                    ce1,
    input  logic [LANES-1:0]        be_n,
    input  logic                    rw,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    input  logic                    pipe_mode,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        lane_drv
);
    localparam int WORD_W = LANES * LANE_W;

    logic [LANES-1:0]  wr_lanes;
    acc_e              st_q;
    logic [LANES-1:0]  mask_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] word;

    psd_ctrl #(.LANES(LANES), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1(ce1), .be_n(be_n),
        .rw(rw), .addr(addr), .wr_lanes(wr_lanes), .st_q(st_q),
        .mask_q(mask_q), .addr_q(addr_q)
    );

    psd_lanes #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_lanes (
        .clk(clk), .wr_lanes(wr_lanes), .wr_addr(addr), .wdata(wdata),
        .rd_addr(addr_q), .rd_word(word)
    );

    psd_outstage #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe_n(oe_n),
        .st_q(st_q), .mask_q(mask_q), .word(word),
        .rdata(rdata), .lane_drv(lane_drv)
    );

    // R7: output disable silences every lane
    p_oe_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (lane_drv == '0 && rdata == '0));

    // R8: nothing drives in the cycle after a write edge
    p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ce0_n && ce1 && !rw && (be_n != '1)) |-> (lane_drv == '0));

    // R5: flow-through drive never exceeds the lanes enabled at the edge
    p_ft_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_mode |-> ((lane_drv & $past(be_n)) == '0));
endmodule

// File: tb/sim_psd_port.sv
`timescale 1ns/1ps
module sim_psd_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce0_n = 1'b1;
    logic        ce1 = 1'b0;
    logic [3:0]  be_n = 4'hF;
    logic        rw = 1'b1;
    logic [5:0]  addr = '0;
    logic [35:0] wdata = '0;
    logic        oe_n = 1'b0;
    logic        pipe_mode = 1'b0;
    logic [35:0] rdata;
    logic [3:0]  lane_drv;

    int nchk = 0;
    int nbad = 0;

    always #2.5 clk = ~clk;

    psd_port u0 (
        .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1(ce1), .be_n(be_n),
        .rw(rw), .addr(addr), .wdata(wdata), .oe_n(oe_n),
        .pipe_mode(pipe_mode), .rdata(rdata), .lane_drv(lane_drv)
    );

    typedef struct packed {
        logic [5:0]  a;
        logic [3:0]  bw;
        logic [3:0]  br;
        logic [35:0] d;
    } vec_t;

    // address, write lane enables, read lane enables, new data (R4, R5, R9, R3)
    localparam vec_t VT [8] = '{
        '{6'd1,  4'h0, 4'h0, 36'h123456789},
        '{6'd2,  4'hE, 4'h0, 36'hFEDCBA987},
        '{6'd3,  4'h5, 4'h0, 36'h0F0F0F0F0},
        '{6'd4,  4'hA, 4'h6, 36'h3C3C3C3C3},
        '{6'd5,  4'h7, 4'h9, 36'hABCDEF012},
        '{6'd6,  4'hF, 4'h0, 36'h111111111},
        '{6'd7,  4'h3, 4'hF, 36'h777777777},
        '{6'd63, 4'hC, 4'h1, 36'hE1E2E3E4E}
    };

    function automatic logic [35:0] base_of(input logic [5:0] a);
        return 36'h5A5A5A5A5 ^ {30'd0, a};
    endfunction

    function automatic logic [35:0] lane_mask(input logic [3:0] en);
        logic [35:0] m = '0;
        for (int i = 0; i < 4; i++)
            if (en[i]) m[i*9 +: 9] = 9'h1FF;
        return m;
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic c0n, input logic c1, input logic r,
                      input logic [3:0] b, input logic [5:0] a, input logic [35:0] d);
        @(negedge clk);
        ce0_n = c0n; ce1 = c1; rw = r; be_n = b; addr = a; wdata = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1000000;
        nbad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        logic [35:0] exp;
        logic [35:0] w1;

        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R10 drv", {32'd0, lane_drv}, 36'd0);
        chk("R10 data", rdata, 36'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // vector table: full base write, partial write, partial read
        for (int i = 0; i < 8; i++) begin
            vec_t v = VT[i];
            op(0, 1, 0, 4'h0, v.a, base_of(v.a));
            op(0, 1, 0, v.bw, v.a, v.d);
            chk("R8 drv after write", {32'd0, lane_drv}, 36'd0);
            op(0, 1, 1, v.br, v.a, '0);
            exp = (v.d & lane_mask(~v.bw)) | (base_of(v.a) & lane_mask(v.bw));
            chk("R5 drv", {32'd0, lane_drv}, {32'd0, ~v.br});
            chk("R4 R9 data", rdata, exp & lane_mask(~v.br));
        end

        // R1: lane positions
        w1 = '0;
        for (int i = 0; i < 4; i++) w1[i*9 +: 9] = 9'h100 | 9'(i + 1);
        op(0, 1, 0, 4'h0, 6'd10, w1);
        op(0, 1, 1, 4'hB, 6'd10, '0);
        chk("R1 lane2 only", rdata, {9'd0, 9'h103, 18'd0});
        op(0, 1, 1, 4'hE, 6'd10, '0);
        chk("R1 lane0 only", rdata, {27'd0, 9'h101});

        // R6: pipelined latency
        pipe_mode = 1'b1;
        op(0, 1, 1, 4'hF, 6'd0, '0);
        op(0, 1, 1, 4'h0, 6'd10, '0);
        chk("R6 no drive at first edge", {32'd0, lane_drv}, 36'd0);
        op(0, 1, 1, 4'hF, 6'd0, '0);
        chk("R6 data one edge later", rdata, w1);
        chk("R6 drv one edge later", {32'd0, lane_drv}, 36'hF);
        op(0, 1, 1, 4'hF, 6'd0, '0);
        chk("R6 drv clears", {32'd0, lane_drv}, 36'd0);

        // R8: write right after a pipelined read blocks drive
        op(0, 1, 1, 4'h0, 6'd10, '0);
        op(0, 1, 0, 4'h0, 6'd20, 36'h0AAAAAAAA);
        chk("R8 pipe drv", {32'd0, lane_drv}, 36'd0);
        op(0, 1, 1, 4'hF, 6'd0, '0);
        chk("R8 pipe drv after", {32'd0, lane_drv}, 36'd0);

        // R7: asynchronous output disable
        pipe_mode = 1'b0;
        op(0, 1, 1, 4'h0, 6'd10, '0);
        chk("R7 before", rdata, w1);
        oe_n = 1'b1;
        #0.5;
        chk("R7 drv off", {32'd0, lane_drv}, 36'd0);
        chk("R7 data off", rdata, 36'd0);
        oe_n = 1'b0;
        #0.5;
        chk("R7 restored", {32'd0, lane_drv}, 36'hF);
        oe_n = 1'b1;
        op(0, 1, 1, 4'h0, 6'd20, '0);
        chk("R7 held off", {32'd0, lane_drv}, 36'd0);
        oe_n = 1'b0;
        #0.5;
        chk("R7 release", rdata, 36'h0AAAAAAAA);

        // R2: deselect by either chip select
        op(1, 1, 0, 4'h0, 6'd10, 36'hFFFFFFFFF);
        op(0, 0, 0, 4'h0, 6'd10, 36'h000000000);
        op(1, 1, 1, 4'h0, 6'd10, '0);
        chk("R2 ce0 drv", {32'd0, lane_drv}, 36'd0);
        op(0, 0, 1, 4'h0, 6'd10, '0);
        chk("R2 ce1 drv", {32'd0, lane_drv}, 36'd0);
        op(0, 1, 1, 4'h0, 6'd10, '0);
        chk("R2 data kept", rdata, w1);

        // R3: selected, no lanes
        op(0, 1, 1, 4'hF, 6'd10, '0);
        chk("R3 no drive", {32'd0, lane_drv}, 36'd0);

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule